// File: doc/BRIEF.md
# Dual Divider Bank Clock Crosspoint

This block sits after a PLL. It takes the oscillator-domain clock and the reference clock and feeds two divider banks. Each bank chooses one of the two clocks as its source. Bank A has a fixed halving divider and a programmable divider. Bank B has fixed dividers by 2, 3 and 4 and a programmable divider. The six bank outputs, the raw reference and a constant-low code are offered to six outputs through a crosspoint. Each output has a 3-bit source code and an enable. A disabled output is released to high-Z, and a flag reports the enable.

The block is synchronous to a fast sampling clock `clk`. Both source clocks are sampled on it and must toggle no faster than once per `clk` cycle. A divider advances on each detected rising edge of its bank's source.

Each output is governed by a small state machine with two states:
- **SEL_RUN** passes the current source through. When the requested code differs from the current one, it takes the transition **request-change** into SEL_WAIT.
- **SEL_WAIT** keeps passing the old source. It takes the transition **commit** back to SEL_RUN, adopting the new code, on the first edge where both the old and the new source are low. If the request returns to the current code first, it takes the transition **cancel** back to SEL_RUN.

Top module: `cgx_xpoint_gen`

## Requirements
- R1: Bit 7 of a bank's config byte selects that bank's source: 0 selects the oscillator clock, 1 selects the reference clock. The two banks select independently.
- R2: Bits 6..0 of a bank's config byte set its programmable divide value N. The output period is N source periods. The high phase lasts floor(N/2) source periods and the low phase lasts ceil(N/2), so an odd N gives a high phase one source period shorter than the low phase.
- R3: A programmable value below 4 behaves exactly as 4.
- R4: Crosspoint codes are 0 = raw reference, 1 = bank A /N, 2 = bank A /2, 3 = bank B /2, 4 = bank B /3, 5 = bank B /4, 6 = bank B /N and 7 = constant low. The bank B /2 and /4 dividers share a phase, so /2 is low whenever /4 rises.
- R5: The 18-bit route word holds the six 3-bit codes MSB-first in output order. Output 1 is at bits 17:15, output 2 at bits 14:12, and so on down to output 6 at bits 2:0.
- R6: Code 0 passes the reference clock to the output with its own high and low times.
- R7: Code 7 holds an enabled output low.
- R8: Enable bit k (bit 0 = output 1) drives flag bit k. When the bit is 0, the output is released to high-Z and is never driven high.
- R9: A code change takes effect only on an edge where both the old and the new source were low. No high pulse shorter than either source's high phase appears during switching.
- R10: After reset all dividers restart low, all outputs start on code 7, and an output reaches its requested code through the switch rule of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| vco_clk | input | 1 | Oscillator-domain source clock (level, sampled on clk) |
| ref_clk | input | 1 | Reference source clock (level, sampled on clk) |
| bank_a_cfg | input | 8 | Bank A: bit 7 source select, bits 6..0 divide value |
| bank_b_cfg | input | 8 | Bank B: bit 7 source select, bits 6..0 divide value |
| route_sel | input | 18 | Six 3-bit crosspoint codes, output 1 in the top bits |
| out_en | input | 6 | Per-output enable, bit 0 = output 1 |
| clk_o | output | 6 | Six clock outputs, high-Z when disabled |
| clk_oe | output | 6 | Per-output driven flag |

## Verification
A source rising edge changes a divider output on the next `clk` edge. The reference bypass is combinational. A new code is adopted on the first edge where the old and new sources are both low, which can take up to one source period of the slower clock. Because of that variable latency, each check first waits a settle interval of several hundred cycles after any configuration change. It then measures a whole high phase and a whole low phase in `clk` cycles, starting at an observed rising edge, and compares them with N times the source period. The bench drives the sources just after the rising edge of `clk` and samples at the falling edge.

// File: rtl/cgx_pkg.sv
package cgx_pkg;
    typedef enum logic {
        SEL_RUN  = 1'b0,
        SEL_WAIT = 1'b1
    } sel_state_e;

    localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/cgx_divider.sv
module cgx_divider #(
    parameter int unsigned NW   = 7,
    parameter int unsigned NMIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [NW-1:0] div,
    output logic          div_o
);
    logic [NW-1:0] eff;
    logic [NW-1:0] low_len;
    logic [NW-1:0] cnt;

    // Values below the floor are raised to it.
    always_comb begin
        eff     = (div < NW'(NMIN)) ? NW'(NMIN) : div;
        low_len = eff - (eff >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt >= eff - NW'(1)) ? '0 : cnt + NW'(1);
    end

    // Low first, then the (possibly shorter) high phase.
    assign div_o = (cnt >= low_len);
endmodule

// File: rtl/cgx_bank.sv
module cgx_bank #(
    parameter int unsigned NW      = 7,
    parameter int unsigned NMIN    = 4,
    parameter int unsigned TOP_FIX = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vco_rise,
    input  logic               ref_rise,
    input  logic [NW:0]        cfg,
    output logic               tick,
    output logic [TOP_FIX-2:0] fix_o,
    output logic               n_o
);
    assign tick = cfg[NW] ? ref_rise : vco_rise;

    for (genvar d = 2; d <= TOP_FIX; d++) begin : g_fix
        cgx_divider #(.NW(NW), .NMIN(2)) u_fix (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .div   (NW'(d)),
            .div_o (fix_o[d-2])
        );
    end

    cgx_divider #(.NW(NW), .NMIN(NMIN)) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .div   (cfg[NW-1:0]),
        .div_o (n_o)
    );
endmodule

// File: rtl/cgx_outsel.sv
module cgx_outsel
    import cgx_pkg::*;
#(
    parameter int unsigned SW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2**SW-1:0]  srcs,
    input  logic [SW-1:0]     req,
    output logic [SW-1:0]     cur,
    output logic              val
);
    sel_state_e state, state_n;
    logic [SW-1:0] cur_q, cur_n;

    always_comb begin
        state_n = state;
        cur_n   = cur_q;
        unique case (state)
            SEL_RUN: begin
                if (req != cur_q)
                    state_n = SEL_WAIT;          // request-change
            end
            SEL_WAIT: begin
                if (req == cur_q)
                    state_n = SEL_RUN;           // cancel
                else if (!srcs[cur_q] && !srcs[req]) begin
                    cur_n   = req;               // commit
                    state_n = SEL_RUN;
                end
            end
            default: state_n = SEL_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEL_RUN;
            cur_q <= '1;                         // top code: held low
        end else begin
            state <= state_n;
            cur_q <= cur_n;
        end
    end

    always_comb begin
        cur = cur_q;
        val = srcs[cur_q];
    end
endmodule

// File: rtl/cgx_xpoint_gen.sv
module cgx_xpoint_gen #(
    parameter int unsigned NOUT = 6,
    parameter int unsigned NW   = 7,
    parameter int unsigned NMIN = 4,
    parameter int unsigned SW   = cgx_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vco_clk,
    input  logic              ref_clk,
    input  logic [NW:0]       bank_a_cfg,
    input  logic [NW:0]       bank_b_cfg,
    input  logic [NOUT*SW-1:0] route_sel,
    input  logic [NOUT-1:0]   out_en,
    output wire  [NOUT-1:0]   clk_o,
    output logic [NOUT-1:0]   clk_oe
);
    localparam int unsigned NSRC = 2**SW;

    logic vco_q, ref_q, vco_rise, ref_rise;
    logic tick_a, tick_b;
    logic [0:0] a_fix;
    logic [2:0] b_fix;
    logic a_n, b_n;
    logic [NSRC-1:0] src_vec;
    logic [NOUT*SW-1:0] cur_flat;
    logic [NOUT-1:0] val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vco_q <= 1'b0;
            ref_q <= 1'b0;
        end else begin
            vco_q <= vco_clk;
            ref_q <= ref_clk;
        end
    end

    assign vco_rise = vco_clk & ~vco_q;
    assign ref_rise = ref_clk & ~ref_q;

    cgx_bank #(.NW(NW), .NMIN(NMIN), .TOP_FIX(2)) u_bank_a (
        .clk (clk), .rst_n (rst_n), .vco_rise (vco_rise), .ref_rise (ref_rise),
        .cfg (bank_a_cfg), .tick (tick_a), .fix_o (a_fix), .n_o (a_n)
    );

    cgx_bank #(.NW(NW), .NMIN(NMIN), .TOP_FIX(4)) u_bank_b (
        .clk (clk), .rst_n (rst_n), .vco_rise (vco_rise), .ref_rise (ref_rise),
        .cfg (bank_b_cfg), .tick (tick_b), .fix_o (b_fix), .n_o (b_n)
    );

    // Code order: ref, A/N, A/2, B/2, B/3, B/4, B/N, low.
    assign src_vec = {1'b0, b_n, b_fix[2], b_fix[1], b_fix[0], a_fix[0], a_n, ref_clk};

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        cgx_outsel #(.SW(SW)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .srcs  (src_vec),
            .req   (route_sel[(NOUT-1-i)*SW +: SW]),
            .cur   (cur_flat[i*SW +: SW]),
            .val   (val[i])
        );
        assign clk_o[i] = out_en[i] ? val[i] : 1'bz;
    end

    assign clk_oe = out_en;
endmodule

// File: rtl/cgx_xpoint_chk.sv
module cgx_xpoint_chk #(
    parameter int unsigned NOUT = 6,
    parameter int unsigned SW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_a,
    input logic              tick_b,
    input logic              a_half,
    input logic              b_half,
    input logic              b_quarter,
    input logic [2**SW-1:0]  src_vec,
    input logic [NOUT*SW-1:0] cur_flat,
    input logic [NOUT-1:0]   out_en,
    input logic [NOUT-1:0]   clk_o
);
    logic [2**SW-1:0]   prev_src;
    logic [NOUT*SW-1:0] prev_cur;
    logic               seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_src <= '0;
            prev_cur <= '1;
            seen     <= 1'b0;
        end else begin
            prev_src <= src_vec;
            prev_cur <= cur_flat;
            seen     <= 1'b1;
        end
    end

    // R2
    a_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_a |=> $stable(a_half));

    // R2
    b_hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_b |=> $stable(b_half));

    // R4
    quarter_half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_quarter) |-> !b_half);

    for (genvar i = 0; i < NOUT; i++) begin : g_o
        // R9
        switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (seen && cur_flat[i*SW +: SW] != prev_cur[i*SW +: SW]) |->
            (!prev_src[prev_cur[i*SW +: SW]] && !prev_src[cur_flat[i*SW +: SW]]));

        // R8
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[i] |-> (clk_o[i] !== 1'b1));
    end
endmodule

bind cgx_xpoint_gen cgx_xpoint_chk #(.NOUT(NOUT), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_a    (tick_a),
    .tick_b    (tick_b),
    .a_half    (a_fix[0]),
    .b_half    (b_fix[0]),
    .b_quarter (b_fix[2]),
    .src_vec   (src_vec),
    .cur_flat  (cur_flat),
    .out_en    (out_en),
    .clk_o     (clk_o)
);

// File: tb/sim_cgx_xpoint_gen.sv
module sim_cgx_xpoint_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic [7:0]  bank_a_cfg = 8'd5;
    logic [7:0]  bank_b_cfg = 8'd5;
    logic [17:0] route_sel = '1;
    logic [5:0]  out_en = '0;
    wire  [5:0]  clk_o;
    logic [5:0]  clk_oe;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    int ref_cnt = 0;

    cgx_xpoint_gen u0 (
        .clk (clk), .rst_n (rst_n), .vco_clk (vco_clk), .ref_clk (ref_clk),
        .bank_a_cfg (bank_a_cfg), .bank_b_cfg (bank_b_cfg),
        .route_sel (route_sel), .out_en (out_en),
        .clk_o (clk_o), .clk_oe (clk_oe)
    );

    always #5 clk = ~clk;

    // Oscillator source: period 2 clk cycles. Reference: period 6 clk cycles.
    initial forever begin
        @(posedge clk);
        #2;
        vco_clk = ~vco_clk;
        ref_cnt = ref_cnt + 1;
        if (ref_cnt == 3) begin
            ref_cnt = 0;
            ref_clk = ~ref_clk;
        end
    end

    initial forever begin
        @(posedge clk);
        cycles = cycles + 1;
        if (cycles > 150000) begin
            errs = errs + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errs = errs + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic set_code(input int o, input int code);
        route_sel[(6-o)*3 +: 3] = code[2:0];
    endtask

    task automatic settle();
        repeat (400) @(negedge clk);
    endtask

    task automatic measure(input int o, output int hi, output int lo);
        int t;
        hi = 0;
        lo = 0;
        t = 0;
        @(negedge clk);
        while (clk_o[o-1] === 1'b1 && t < 3000) begin @(negedge clk); t++; end
        while (clk_o[o-1] !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
        while (clk_o[o-1] === 1'b1 && t < 3000) begin @(negedge clk); t++; hi++; end
        while (clk_o[o-1] !== 1'b1 && t < 3000) begin @(negedge clk); t++; lo++; end
    endtask

    task automatic run_meas(input string req, input int o, input int eh, input int el);
        int h, l;
        settle();
        measure(o, h, l);
        chk({req, " high"}, h, eh);
        chk({req, " low"}, l, el);
    endtask

    task automatic t_reset();
        int bad = 0;
        @(negedge clk);
        chk("R8 reset flags", int'(clk_oe), 0);
        for (int k = 0; k < 6; k++) if (clk_o[k] === 1'b1) bad++;
        chk("R8 reset outputs", bad, 0);
    endtask

    task automatic t_code7();
        int hits = 0;
        out_en = '1;
        route_sel = '1;
        repeat (50) @(negedge clk);
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (clk_o !== 6'b0) hits++;
        end
        chk("R7 R10 code 7 low cycles", hits, 0);
    endtask

    task automatic t_bypass();
        set_code(1, 0);
        run_meas("R6 ref bypass", 1, 3, 3);
    endtask

    task automatic t_bank_a();
        bank_a_cfg = {1'b0, 7'd5};
        set_code(1, 1);
        run_meas("R2 A/N odd N=5", 1, 4, 6);
        set_code(1, 2);
        run_meas("R4 A/2", 1, 2, 2);
        bank_a_cfg = {1'b0, 7'd127};
        set_code(1, 1);
        run_meas("R2 A/N N=127", 1, 126, 128);
        bank_a_cfg = {1'b1, 7'd5};
        run_meas("R1 A source ref", 1, 12, 18);
    endtask

    task automatic t_bank_b();
        bank_b_cfg = {1'b1, 7'd9};
        set_code(2, 3);
        run_meas("R4 B/2", 2, 6, 6);
        set_code(2, 4);
        run_meas("R4 B/3", 2, 6, 12);
        set_code(2, 5);
        run_meas("R4 B/4", 2, 12, 12);
        bank_b_cfg = {1'b0, 7'd2};
        set_code(3, 6);
        run_meas("R3 B/N value 2", 3, 4, 4);
        bank_b_cfg = {1'b0, 7'd0};
        run_meas("R3 B/N value 0", 3, 4, 4);
    endtask

    task automatic t_independent();
        int h1, l1, h2, l2;
        bank_a_cfg = {1'b0, 7'd6};
        bank_b_cfg = {1'b1, 7'd7};
        set_code(1, 1);
        set_code(2, 6);
        settle();
        measure(1, h1, l1);
        measure(2, h2, l2);
        chk("R1 A on vco high", h1, 6);
        chk("R1 A on vco low", l1, 6);
        chk("R1 B on ref high", h2, 18);
        chk("R1 B on ref low", l2, 24);
    endtask

    task automatic t_packing();
        int hits = 0;
        route_sel = '1;
        set_code(6, 0);
        run_meas("R5 output 6 field", 6, 3, 3);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (clk_o[4:0] !== 5'b0) hits++;
        end
        chk("R5 outputs 1-5 low", hits, 0);
    endtask

    task automatic t_enable();
        int hi_seen = 0;
        route_sel = '0;
        out_en = 6'b111110;
        settle();
        chk("R8 flag mirrors enables", int'(clk_oe), 6'b111110);
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (clk_o[0] === 1'b1) hi_seen++;
        end
        chk("R8 disabled output 1 never high", hi_seen, 0);
        out_en = '1;
    endtask

    task automatic t_glitch();
        int run = 0;
        int runts = 0;
        bank_b_cfg = {1'b1, 7'd9};
        set_code(1, 5);
        settle();
        for (int c = 0; c < 3000; c++) begin
            if (c % 37 == 0) set_code(1, (route_sel[17:15] == 3'd5) ? 2 : 5);
            @(negedge clk);
            if (clk_o[0] === 1'b1) run++;
            else begin
                if (run > 0 && run < 2) runts++;
                run = 0;
            end
        end
        chk("R9 high runts while switching", runts, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_code7();
        t_bypass();
        t_bank_a();
        t_bank_b();
        t_independent();
        t_packing();
        t_enable();
        t_glitch();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule